// File: doc/BRIEF.md
# Host Command and Result Latch Port

This block sits between an external host processor and a dual-channel signalling core. The host talks to it over an 8-bit data path with two active-low strobes that are not related to the system clock. A write strobe loads one byte into an input latch. A read strobe presents the contents of an output latch. Two handshake flags pace the host. One flag reports that the input latch is occupied. The other, active low, reports that a result byte is waiting.

Inside the chip, the block sorts each written byte by its leading bits. A byte can be one of two configuration words, a tone-transmit command, or an unused pattern. It holds the decoded configuration as plain outputs and issues a one-cycle transmit strobe that carries the channel and the tone code. The core posts result bytes into the output latch through a simple valid/data path. The block does not interpret tone codes.

After reset, the port places 00h in the output latch and raises the result-waiting indication, so the host can tell that the device is running. The host must keep its data stable for at least three system clocks after the write strobe rises. Reset is expected to be held low for at least five clocks.

Top module: `host_latch_port`

## Requirements
- R1: Within four system clocks of the write strobe going low, `in_flag` is high.
- R2: The byte on `bus_in` when the synchronized write strobe rises is taken by the core. `in_flag` then returns low within eight clocks of that rise.
- R3: A cycle with `post_valid` high loads `post_data` into the output latch and drives `out_flag_n` low on the next clock.
- R4: While the read strobe is low (after synchronization), `bus_oe` is high and `bus_out` carries the output latch. A falling read strobe drives `out_flag_n` high. Once the read strobe is high again, `bus_oe` returns low.
- R5: A written byte with bits 7:6 = 00 sets the following fields: `cfg_ext_clk` from bit 5, `cfg_binary` from bit 4, channel-1 enable (`cfg_ch_en[0]`) from bit 3, channel-1 long-KP timing (`cfg_kp_long[0]`) from bit 2, and channel-1 KP gating (`cfg_kp_gate[0]`) from bit 1. All other settings are left unchanged.
- R6: A written byte with bits 7:5 = 010 sets `cfg_alaw` from bit 4, `cfg_ch_en[1]` from bit 3, `cfg_kp_long[1]` from bit 2 and `cfg_kp_gate[1]` from bit 1. All other settings are left unchanged.
- R7: A written byte with bit 7 = 1 is a transmit command. If the selected channel is enabled, the block emits exactly one cycle of `tx_valid`. In that cycle, `tx_chan` equals bit 6 (1 selects channel 2) and `tx_code` equals bits 5:0.
- R8: During reset, `in_flag` is 0, `out_flag_n` is 1 and `bus_oe` is 0. Both channels are disabled, 2-of-6 mode is selected (`cfg_binary` = 0), external clocking is selected (`cfg_ext_clk` = 1), mu-law is selected, and all KP bits are 0.
- R9: In the first cycle after reset, the output latch holds 00h and `out_flag_n` is low.
- R10: A written byte with bits 7:5 = 011 is consumed (`in_flag` clears), but it changes no setting and produces no transmit strobe.
- R11: A transmit command aimed at a disabled channel is consumed without producing a `tx_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_n | input | 1 | Host write strobe, active low, asynchronous |
| rd_n | input | 1 | Host read strobe, active low, asynchronous |
| bus_in | input | 8 | Host data toward the input latch |
| bus_out | output | 8 | Output latch contents toward the host |
| bus_oe | output | 1 | Drive enable for the host data bus |
| in_flag | output | 1 | Input latch occupied |
| out_flag_n | output | 1 | Low while a result byte waits |
| post_valid | input | 1 | Core posts a result byte this cycle |
| post_data | input | 8 | Result byte from the core |
| cfg_ext_clk | output | 1 | External serial clocking selected |
| cfg_binary | output | 1 | Binary code format selected (0 = 2-of-6) |
| cfg_alaw | output | 1 | A-law companding selected (0 = mu-law) |
| cfg_ch_en | output | 2 | Per-channel enable, bit 0 = channel 1 |
| cfg_kp_long | output | 2 | Per-channel long KP detection time |
| cfg_kp_gate | output | 2 | Per-channel detection gated by KP |
| tx_valid | output | 1 | One-cycle transmit command strobe |
| tx_chan | output | 1 | Transmit channel, 1 = channel 2 |
| tx_code | output | 6 | Transmit tone code |

## Verification
On every cycle, the assertions check that a transmit strobe lasts exactly one cycle and never targets a disabled channel. They also check that a post pulls the waiting flag low, that a read start raises it, and that settings change only in the cycle a written byte is consumed. The bench scenarios are needed for the rest: the exact field mapping of both configuration words, the ignored pattern, the life-sign byte after reset, and the values seen on the bus during a read. A scoreboard matches every transmit strobe against the commands that should have produced one.

// File: rtl/hlp_pkg.sv
// Shared types and constants for the host latch port.
// Assumes a fixed two-channel core and an 8-bit host data path.
package hlp_pkg;
    localparam int BYTE_W = 8;
    localparam int CODE_W = 6;
    localparam int NCH    = 2;

    typedef enum logic [1:0] {
        KIND_CFG1 = 2'd0,
        KIND_CFG2 = 2'd1,
        KIND_TONE = 2'd2,
        KIND_NONE = 2'd3
    } kind_e;

    typedef struct packed {
        logic             ext_clk;
        logic             binary;
        logic             alaw;
        logic [NCH-1:0]   ch_en;
        logic [NCH-1:0]   kp_long;
        logic [NCH-1:0]   kp_gate;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{
        ext_clk: 1'b1,
        binary:  1'b0,
        alaw:    1'b0,
        ch_en:   '0,
        kp_long: '0,
        kp_gate: '0
    };

    // Sort a host byte by its leading bits.
    function automatic kind_e classify(input logic [BYTE_W-1:0] b);
        if (b[7])                 return KIND_TONE;
        else if (!b[6])           return KIND_CFG1;
        else if (!b[5])           return KIND_CFG2;
        else                      return KIND_NONE;
    endfunction
endpackage

// File: rtl/hlp_sync.sv
// Multi-stage synchronizer for asynchronous level inputs.
// Assumes each bit is an independent level; no bus coherency implied.
module hlp_sync #(
    parameter int               WIDTH   = 2,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain [STAGES];

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= async_in;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/hlp_cmd_decode.sv
// Input latch, occupancy flag and byte decoder.
// Captures the host byte on a synchronized write rise, consumes it one
// cycle later, updates settings or issues a transmit strobe.
// Assumes the host keeps bus_in stable for three clocks after the rise.
module hlp_cmd_decode
    import hlp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_fall,
    input  logic              wr_rise,
    input  logic [BYTE_W-1:0] bus_in,
    output logic              in_flag,
    output cfg_t              cfg,
    output logic              tx_valid,
    output logic              tx_chan,
    output logic [CODE_W-1:0] tx_code
);
    logic [BYTE_W-1:0] held_q;
    logic              have_q;
    kind_e             kind;

    assign kind = classify(held_q);

    // Latch, consume and decode host bytes; flag tracks occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_flag  <= 1'b0;
            have_q   <= 1'b0;
            held_q   <= '0;
            cfg      <= CFG_RESET;
            tx_valid <= 1'b0;
            tx_chan  <= 1'b0;
            tx_code  <= '0;
        end else begin
            tx_valid <= 1'b0;
            if (have_q) begin
                have_q  <= 1'b0;
                in_flag <= 1'b0;
                case (kind)
                    KIND_CFG1: begin
                        cfg.ext_clk    <= held_q[5];
                        cfg.binary     <= held_q[4];
                        cfg.ch_en[0]   <= held_q[3];
                        cfg.kp_long[0] <= held_q[2];
                        cfg.kp_gate[0] <= held_q[1];
                    end
                    KIND_CFG2: begin
                        cfg.alaw       <= held_q[4];
                        cfg.ch_en[1]   <= held_q[3];
                        cfg.kp_long[1] <= held_q[2];
                        cfg.kp_gate[1] <= held_q[1];
                    end
                    KIND_TONE: begin
                        if (cfg.ch_en[held_q[6]]) begin
                            tx_valid <= 1'b1;
                            tx_chan  <= held_q[6];
                            tx_code  <= held_q[CODE_W-1:0];
                        end
                    end
                    default: ;
                endcase
            end
            if (wr_fall) in_flag <= 1'b1;
            if (wr_rise) begin
                held_q  <= bus_in;
                have_q  <= 1'b1;
                in_flag <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/hlp_out_latch.sv
// Output latch and result-waiting flag (active low).
// Posts 00h once after reset as a life sign; a core post overrides a
// same-cycle read start so a fresh result is never hidden.
module hlp_out_latch
    import hlp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              post_valid,
    input  logic [BYTE_W-1:0] post_data,
    input  logic              rd_fall,
    output logic [BYTE_W-1:0] latch_q,
    output logic              flag_n
);
    logic boot_q;

    // Load results, post the life sign, clear waiting flag on read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boot_q  <= 1'b1;
            latch_q <= '0;
            flag_n  <= 1'b1;
        end else begin
            if (rd_fall) flag_n <= 1'b1;
            if (boot_q) begin
                boot_q  <= 1'b0;
                latch_q <= '0;
                flag_n  <= 1'b0;
            end else if (post_valid) begin
                latch_q <= post_data;
                flag_n  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/host_latch_port.sv
// Host-facing byte port: synchronizes the asynchronous strobes, finds
// their edges, and ties the input decoder and output latch together.
// Assumes strobes pulse for at least three clocks each.
module host_latch_port
    import hlp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic [BYTE_W-1:0] bus_in,
    output logic [BYTE_W-1:0] bus_out,
    output logic              bus_oe,
    output logic              in_flag,
    output logic              out_flag_n,
    input  logic              post_valid,
    input  logic [BYTE_W-1:0] post_data,
    output logic              cfg_ext_clk,
    output logic              cfg_binary,
    output logic              cfg_alaw,
    output logic [NCH-1:0]    cfg_ch_en,
    output logic [NCH-1:0]    cfg_kp_long,
    output logic [NCH-1:0]    cfg_kp_gate,
    output logic              tx_valid,
    output logic              tx_chan,
    output logic [CODE_W-1:0] tx_code
);
    logic [1:0] strobe_s;
    logic [1:0] strobe_prev;
    logic       wr_s, rd_s;
    logic       wr_fall, wr_rise, rd_fall;
    cfg_t       cfg;

    hlp_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({rd_n, wr_n}),
        .sync_out (strobe_s)
    );

    assign wr_s = strobe_s[0];
    assign rd_s = strobe_s[1];

    // Remember last synchronized strobe levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_prev <= 2'b11;
        else        strobe_prev <= strobe_s;
    end

    assign wr_fall = strobe_prev[0] & ~wr_s;
    assign wr_rise = ~strobe_prev[0] & wr_s;
    assign rd_fall = strobe_prev[1] & ~rd_s;

    hlp_cmd_decode u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_fall  (wr_fall),
        .wr_rise  (wr_rise),
        .bus_in   (bus_in),
        .in_flag  (in_flag),
        .cfg      (cfg),
        .tx_valid (tx_valid),
        .tx_chan  (tx_chan),
        .tx_code  (tx_code)
    );

    hlp_out_latch u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .post_valid (post_valid),
        .post_data  (post_data),
        .rd_fall    (rd_fall),
        .latch_q    (bus_out),
        .flag_n     (out_flag_n)
    );

    assign bus_oe      = ~rd_s;
    assign cfg_ext_clk = cfg.ext_clk;
    assign cfg_binary  = cfg.binary;
    assign cfg_alaw    = cfg.alaw;
    assign cfg_ch_en   = cfg.ch_en;
    assign cfg_kp_long = cfg.kp_long;
    assign cfg_kp_gate = cfg.kp_gate;
endmodule

// File: rtl/hlp_checker.sv
// Protocol checker for host_latch_port, attached by bind.
module hlp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_oe,
    input logic       in_flag,
    input logic       out_flag_n,
    input logic       post_valid,
    input logic       cfg_ext_clk,
    input logic       cfg_binary,
    input logic       cfg_alaw,
    input logic [1:0] cfg_ch_en,
    input logic [1:0] cfg_kp_long,
    input logic [1:0] cfg_kp_gate,
    input logic       tx_valid,
    input logic       tx_chan
);
    logic [8:0] cfg_vec;
    assign cfg_vec = {cfg_ext_clk, cfg_binary, cfg_alaw, cfg_ch_en, cfg_kp_long, cfg_kp_gate};

    p_tx_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |=> !tx_valid);

    p_tx_enabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> cfg_ch_en[tx_chan]);

    p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe) && !post_valid |=> out_flag_n);

    p_post_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        post_valid |=> !out_flag_n);

    p_cfg_on_consume_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_vec) |-> $fell(in_flag));
endmodule

bind host_latch_port hlp_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_oe      (bus_oe),
    .in_flag     (in_flag),
    .out_flag_n  (out_flag_n),
    .post_valid  (post_valid),
    .cfg_ext_clk (cfg_ext_clk),
    .cfg_binary  (cfg_binary),
    .cfg_alaw    (cfg_alaw),
    .cfg_ch_en   (cfg_ch_en),
    .cfg_kp_long (cfg_kp_long),
    .cfg_kp_gate (cfg_kp_gate),
    .tx_valid    (tx_valid),
    .tx_chan     (tx_chan)
);

// File: tb/sim_host_latch_port.sv
module sim_host_latch_port;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_n = 1'b1, rd_n = 1'b1;
    logic [7:0] bus_in = '0, post_data = '0;
    logic       post_valid = 1'b0;
    logic [7:0] bus_out;
    logic       bus_oe, in_flag, out_flag_n;
    logic       cfg_ext_clk, cfg_binary, cfg_alaw;
    logic [1:0] cfg_ch_en, cfg_kp_long, cfg_kp_gate;
    logic       tx_valid, tx_chan;
    logic [5:0] tx_code;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [6:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    host_latch_port u0 (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .in_flag(in_flag), .out_flag_n(out_flag_n),
        .post_valid(post_valid), .post_data(post_data),
        .cfg_ext_clk(cfg_ext_clk), .cfg_binary(cfg_binary), .cfg_alaw(cfg_alaw),
        .cfg_ch_en(cfg_ch_en), .cfg_kp_long(cfg_kp_long), .cfg_kp_gate(cfg_kp_gate),
        .tx_valid(tx_valid), .tx_chan(tx_chan), .tx_code(tx_code)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Compare all settings: {ext, bin, alaw, en[1:0], kpl[1:0], kpg[1:0]}
    task automatic check_cfg(input string req, input logic [8:0] exp);
        check(req, {7'd0, cfg_ext_clk, cfg_binary, cfg_alaw, cfg_ch_en, cfg_kp_long, cfg_kp_gate},
              {7'd0, exp});
    endtask

    // Driver: writes one byte; pushes expected transmit item if due.
    task automatic write_byte(input logic [7:0] b, input bit expect_tx);
        if (expect_tx) exp_q.push_back({b[6], b[5:0]});
        @(negedge clk);
        bus_in = b;
        wr_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 in_flag after write fall", {15'd0, in_flag}, 16'd1);
        wr_n = 1'b1;
        repeat (4) @(negedge clk);
        bus_in = 8'hxx;
        repeat (4) @(negedge clk);
        check("R2 in_flag cleared after consume", {15'd0, in_flag}, 16'd0);
    endtask

    task automatic read_byte(input logic [7:0] exp, input string req);
        @(negedge clk);
        rd_n = 1'b0;
        repeat (4) @(negedge clk);
        check({req, " bus_oe during read"}, {15'd0, bus_oe}, 16'd1);
        check({req, " bus_out during read"}, {8'd0, bus_out}, {8'd0, exp});
        check("R4 out_flag_n high after read start", {15'd0, out_flag_n}, 16'd1);
        rd_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R4 bus released after read", {15'd0, bus_oe}, 16'd0);
    endtask

    task automatic post(input logic [7:0] d);
        @(negedge clk);
        post_data = d;
        post_valid = 1'b1;
        @(negedge clk);
        post_valid = 1'b0;
        check("R3 out_flag_n low after post", {15'd0, out_flag_n}, 16'd0);
    endtask

    // Monitor: pops expected transmit items as strobes appear.
    always @(negedge clk) begin
        if (rst_n && tx_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R11/R10 unexpected tx strobe: actual %0d/%h expected none",
                         tx_chan, tx_code);
            end else begin
                logic [6:0] e;
                e = exp_q.pop_front();
                if ({tx_chan, tx_code} !== e) begin
                    errors++;
                    $display("FAIL R7 tx item: actual %h expected %h", {tx_chan, tx_code}, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
            $finish;
        end
    end

    initial begin
        repeat (6) @(negedge clk);
        // R8 reset state
        check("R8 in_flag in reset", {15'd0, in_flag}, 16'd0);
        check("R8 out_flag_n in reset", {15'd0, out_flag_n}, 16'd1);
        check("R8 bus_oe in reset", {15'd0, bus_oe}, 16'd0);
        check_cfg("R8 settings in reset", 9'b1_0_0_00_00_00);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 life sign
        check("R9 out_flag_n after reset", {15'd0, out_flag_n}, 16'd0);
        check("R9 latch after reset", {8'd0, bus_out}, 16'd0);
        read_byte(8'h00, "R9");

        // R11: channels still disabled
        write_byte(8'h85, 1'b0);
        // R5: cfg1 0010_1110
        write_byte(8'h2E, 1'b0);
        check_cfg("R5 cfg1 first", 9'b1_0_0_01_01_01);
        write_byte(8'h10, 1'b0);
        check_cfg("R5 cfg1 second", 9'b0_1_0_00_00_00);
        write_byte(8'h0E, 1'b0);
        check_cfg("R5 cfg1 third", 9'b0_0_0_01_01_01);
        // R6: cfg2 0101_1010
        write_byte(8'h5A, 1'b0);
        check_cfg("R6 cfg2", 9'b0_0_1_11_01_11);
        // R7 transmit on both channels
        write_byte(8'h85, 1'b1);
        write_byte(8'hE3, 1'b1);
        // R10 ignored pattern
        write_byte(8'h7F, 1'b0);
        check_cfg("R10 settings unchanged", 9'b0_0_1_11_01_11);
        // R11 disable channel 2, then command it
        write_byte(8'h40, 1'b0);
        check_cfg("R6 cfg2 disable", 9'b0_0_0_01_01_01);
        write_byte(8'hC1, 1'b0);
        write_byte(8'h81, 1'b1);
        // R3 / R4 results
        post(8'hA5);
        read_byte(8'hA5, "R3");
        post(8'h3C);
        read_byte(8'h3C, "R4");
        repeat (5) @(negedge clk);
        check("R7 all expected tx strobes seen", 16'(exp_q.size()), 16'd0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule